// File: doc/BRIEF.md
# Serial EEPROM Paged Word Writer

This block is a hardware master for a serial EEPROM on a four-wire SPI bus. A host hands it one request: a start word offset and a word count. The block checks that the run fits inside the device. It then pulls the 16-bit data words from the host one at a time through a ready/valid handshake and writes them into the device.

The run is cut into page-sized bursts. Each burst opens with a status poll, repeated until the device reports that it is no longer busy. A write-enable command follows, framed on its own by chip select. Then comes the write command: the opcode, the byte address and the data words with their two bytes swapped. When the last burst closes, the block waits a settle time and reports completion with a one-cycle pulse that carries an error flag.

Clock division, opcode width, address width, page size, device size, poll limit and the wait times are all parameters.

Top module: `eeprom_page_writer`

## Requirements
- R1: A request is rejected when the offset is at least DEV_WORDS, when the count is zero, or when the count is larger than DEV_WORDS minus the offset. The rejection is `done`=1 with `err`=1 in the cycle after the handshake. No chip-select activity follows.
- R2: Each burst starts with a status poll, framed by chip select. The poll is opcode 0x05 followed by 8 bits shifted in. If status bit 0 is 1 (busy), chip select goes high for POLL_GAP cycles and the poll is repeated. After MAX_POLLS busy reads, the block ends with `done`=1 and `err`=1.
- R3: Before every write command, write-enable (opcode 0x06) is sent as a separate command with its own chip-select frame.
- R4: The write opcode is 0x02. When ADDR_W is 8 and the word offset of the burst is 128 or more, the opcode sent is 0x0A (flag 0x08 added).
- R5: After the opcode comes the byte address, equal to twice the word offset and truncated to ADDR_W bits. It is sent MSB first.
- R6: Data words are taken one at a time through `wd_ready`/`wd_valid`. Each word goes out as 16 clocks: the low byte first, then the high byte, each byte MSB first. `wd_ready` stays high until `wd_valid` is seen.
- R7: A burst ends after the word whose following byte address is a multiple of PAGE_BYTES. If words remain, chip select goes high and the sequence restarts at R2.
- R8: SCK is high for CLK_DIV cycles and low for CLK_DIV cycles. MOSI changes only while SCK is low. MISO is sampled in the last cycle of the high phase, and the received value is built MSB first. MOSI is held low while status bits are read.
- R9: After the last data word, chip select goes high. `done`=1 with `err`=0 follows exactly SETTLE cycles after that edge.
- R10: CS is active low and idles high. SCK is low whenever CS is high. `done` is a single-cycle pulse, and `err` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request presented |
| req_ready | output | 1 | Block is idle and accepts a request |
| req_offset | input | REQ_W | Start word offset |
| req_count | input | REQ_W | Number of words |
| wd_valid | input | 1 | Data word presented |
| wd_ready | output | 1 | Block takes the next data word |
| wd_data | input | 16 | Data word |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, valid with `done` |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |

## Verification
Two decisions fall on the same data word:
- the page-boundary test, which ends the burst;
- the last-word test, which ends the run.

When a run ends exactly on a page boundary, only the completion path may be taken, and no further status poll may appear. The bench provokes this with a run that fills exactly one page, and with a run that crosses a boundary and also crosses the word-128 line where the opcode flag changes. A device model on the pins records every chip-select frame byte by byte. The recorded frames are compared against a frame list that the bench builds from the requirements, and any extra or missing poll frame is reported as a miscompare.

// File: rtl/epw_pkg.sv
package epw_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_SHIFT, ST_WORD} epw_state_e;
   typedef enum logic [2:0] {SP_POLL_OP, SP_POLL_RD, SP_WREN, SP_WROP, SP_ADDR, SP_DATA} epw_step_e;
   typedef enum logic [1:0] {RT_POLL, RT_WREN, RT_WROP, RT_FIN} epw_ret_e;

   localparam logic [7:0] OPC_STATUS = 8'h05;
   localparam logic [7:0] OPC_WENA   = 8'h06;
   localparam logic [7:0] OPC_WRITE  = 8'h02;
   localparam logic [7:0] OPC_HI_ADR = 8'h08;
endpackage

// File: rtl/eeprom_req_check.sv
module eeprom_req_check #(
   parameter int REQ_W     = 16,
   parameter int DEV_WORDS = 256
) (
   input  logic [REQ_W-1:0] ofs,
   input  logic [REQ_W-1:0] cnt,
   output logic             bad
);
   localparam logic [REQ_W:0] DEV_L = (REQ_W+1)'(DEV_WORDS);

   logic [REQ_W:0] ofs_x, cnt_x, room;

   always_comb begin
      ofs_x = {1'b0, ofs};
      cnt_x = {1'b0, cnt};
      room  = DEV_L - ofs_x;
      bad   = (ofs_x >= DEV_L) || (cnt_x == '0) || (cnt_x > room);
   end
endmodule

// File: rtl/eeprom_cmd_fmt.sv
module eeprom_cmd_fmt #(
   parameter int OPC_W  = 8,
   parameter int ADDR_W = 8,
   parameter int REQ_W  = 16
) (
   input  logic [REQ_W-1:0]  word_ofs,
   output logic [OPC_W-1:0]  wr_opc,
   output logic [ADDR_W-1:0] byte_addr
);
   import epw_pkg::*;

   logic [REQ_W+ADDR_W:0] ext;

   always_comb begin
      ext       = {{ADDR_W{1'b0}}, word_ofs, 1'b0};
      byte_addr = ext[ADDR_W-1:0];
   end

   generate
      if (ADDR_W == 8) begin : g_hi_flag
         always_comb begin
            wr_opc = OPC_W'(OPC_WRITE);
            if (word_ofs >= REQ_W'(128)) wr_opc = OPC_W'(OPC_WRITE | OPC_HI_ADR);
         end
      end else begin : g_plain
         assign wr_opc = OPC_W'(OPC_WRITE);
      end
   endgenerate
endmodule

// File: rtl/eeprom_spi_shifter.sv
module eeprom_spi_shifter #(
   parameter int CLK_DIV = 4,
   parameter int MAXB    = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          start,
   input  logic [$clog2(MAXB+1)-1:0]     nbits,
   input  logic [MAXB-1:0]               tx,
   input  logic                          rx_mode,
   input  logic                          miso,
   output logic                          sck,
   output logic                          mosi,
   output logic                          busy,
   output logic                          done,
   output logic [MAXB-1:0]               rx
);
   localparam int NB_W  = $clog2(MAXB+1);
   localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

   logic [MAXB-1:0]  shreg;
   logic [NB_W-1:0]  left;
   logic [DIV_W-1:0] cnt;
   logic             hi, rxm;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sck <= 1'b0; mosi <= 1'b0; busy <= 1'b0; done <= 1'b0;
         rx <= '0; shreg <= '0; left <= '0; cnt <= '0; hi <= 1'b0; rxm <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy) begin
            if (start) begin
               busy  <= 1'b1;
               shreg <= tx << (MAXB - int'(nbits));
               left  <= nbits;
               hi    <= 1'b0;
               cnt   <= '0;
               rxm   <= rx_mode;
               rx    <= '0;
               mosi  <= rx_mode ? 1'b0 : tx[nbits - NB_W'(1)];
            end
         end else if (cnt == DIV_W'(CLK_DIV-1)) begin
            cnt <= '0;
            if (!hi) begin
               sck <= 1'b1;
               hi  <= 1'b1;
            end else begin
               sck   <= 1'b0;
               hi    <= 1'b0;
               rx    <= {rx[MAXB-2:0], miso};
               shreg <= shreg << 1;
               left  <= left - NB_W'(1);
               if (left == NB_W'(1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
                  mosi <= 1'b0;
               end else begin
                  mosi <= rxm ? 1'b0 : shreg[MAXB-2];
               end
            end
         end else begin
            cnt <= cnt + DIV_W'(1);
         end
      end
   end

   AST_RX_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && rxm) |-> !mosi);                           // R8
   AST_SCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sck);                                     // R10
   AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy);                                    // R8
   AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sck && $past(sck)) |-> $stable(mosi));              // R8
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
   parameter int CLK_DIV    = 4,
   parameter int OPC_W      = 8,
   parameter int ADDR_W     = 8,
   parameter int PAGE_BYTES = 32,
   parameter int DEV_WORDS  = 256,
   parameter int REQ_W      = 16,
   parameter int MAX_POLLS  = 1000,
   parameter int POLL_GAP   = 250,
   parameter int SETTLE     = 500000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [REQ_W-1:0] req_offset,
   input  logic [REQ_W-1:0] req_count,
   input  logic             wd_valid,
   output logic             wd_ready,
   input  logic [15:0]      wd_data,
   output logic             done,
   output logic             err,
   output logic             spi_sck,
   output logic             spi_cs_n,
   output logic             spi_mosi,
   input  logic             spi_miso
);
   import epw_pkg::*;

   localparam int MAXB   = 16;
   localparam int NB_W   = $clog2(MAXB+1);
   localparam int POLL_W = $clog2(MAX_POLLS+1);
   localparam int CS_GAP = 2*CLK_DIV;
   localparam logic [REQ_W:0] PG_MASK = (REQ_W+1)'(PAGE_BYTES-1);

   if ((PAGE_BYTES & (PAGE_BYTES-1)) != 0 || PAGE_BYTES < 2) begin : g_chk_page
      $error("PAGE_BYTES must be a power of two, at least 2");
   end
   if (OPC_W < 8 || OPC_W > MAXB) begin : g_chk_opc
      $error("OPC_W out of range");
   end
   if (ADDR_W < 1 || ADDR_W > MAXB) begin : g_chk_addr
      $error("ADDR_W out of range");
   end
   if (CLK_DIV < 1 || MAX_POLLS < 1 || POLL_GAP < 1 || SETTLE < 1) begin : g_chk_time
      $error("timing parameters must be positive");
   end

   epw_state_e       state;
   epw_step_e        step;
   epw_ret_e         ret;
   logic [REQ_W-1:0] cur, left;
   logic [POLL_W-1:0] polls;
   logic [31:0]      wcnt;

   logic             sh_start, sh_rxm, sh_busy, sh_done;
   logic [NB_W-1:0]  sh_bits;
   logic [MAXB-1:0]  sh_tx, sh_rx;

   logic             req_bad;
   logic [OPC_W-1:0] wr_opc;
   logic [ADDR_W-1:0] byte_addr;
   logic [REQ_W:0]   next_b;
   logic             page_end;

   eeprom_req_check #(.REQ_W(REQ_W), .DEV_WORDS(DEV_WORDS)) u_chk (
      .ofs(req_offset), .cnt(req_count), .bad(req_bad));

   eeprom_cmd_fmt #(.OPC_W(OPC_W), .ADDR_W(ADDR_W), .REQ_W(REQ_W)) u_fmt (
      .word_ofs(cur), .wr_opc(wr_opc), .byte_addr(byte_addr));

   eeprom_spi_shifter #(.CLK_DIV(CLK_DIV), .MAXB(MAXB)) u_shf (
      .clk(clk), .rst_n(rst_n), .start(sh_start), .nbits(sh_bits), .tx(sh_tx),
      .rx_mode(sh_rxm), .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi),
      .busy(sh_busy), .done(sh_done), .rx(sh_rx));

   assign req_ready = (state == ST_IDLE);
   assign wd_ready  = (state == ST_WORD);
   assign next_b    = {cur + REQ_W'(1), 1'b0};
   assign page_end  = (next_b & PG_MASK) == '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE; step <= SP_POLL_OP; ret <= RT_POLL;
         cur <= '0; left <= '0; polls <= '0; wcnt <= '0;
         spi_cs_n <= 1'b1; done <= 1'b0; err <= 1'b0;
         sh_start <= 1'b0; sh_rxm <= 1'b0; sh_bits <= '0; sh_tx <= '0;
      end else begin
         done     <= 1'b0;
         err      <= 1'b0;
         sh_start <= 1'b0;
         unique case (state)
            ST_IDLE: if (req_valid) begin
               if (req_bad) begin
                  done <= 1'b1;
                  err  <= 1'b1;
               end else begin
                  cur <= req_offset; left <= req_count; polls <= '0;
                  spi_cs_n <= 1'b0;
                  sh_start <= 1'b1; sh_rxm <= 1'b0;
                  sh_bits <= NB_W'(OPC_W); sh_tx <= MAXB'(OPC_STATUS);
                  step <= SP_POLL_OP; state <= ST_SHIFT;
               end
            end
            ST_WAIT: if (wcnt == '0) begin
               unique case (ret)
                  RT_FIN: begin
                     done <= 1'b1;
                     state <= ST_IDLE;
                  end
                  RT_POLL: begin
                     spi_cs_n <= 1'b0; sh_start <= 1'b1; sh_rxm <= 1'b0;
                     sh_bits <= NB_W'(OPC_W); sh_tx <= MAXB'(OPC_STATUS);
                     step <= SP_POLL_OP; state <= ST_SHIFT;
                  end
                  RT_WREN: begin
                     spi_cs_n <= 1'b0; sh_start <= 1'b1; sh_rxm <= 1'b0;
                     sh_bits <= NB_W'(OPC_W); sh_tx <= MAXB'(OPC_WENA);
                     step <= SP_WREN; state <= ST_SHIFT;
                  end
                  default: begin
                     spi_cs_n <= 1'b0; sh_start <= 1'b1; sh_rxm <= 1'b0;
                     sh_bits <= NB_W'(OPC_W); sh_tx <= MAXB'(wr_opc);
                     step <= SP_WROP; state <= ST_SHIFT;
                  end
               endcase
            end else begin
               wcnt <= wcnt - 32'd1;
            end
            ST_WORD: if (wd_valid) begin
               sh_start <= 1'b1; sh_rxm <= 1'b0; sh_bits <= NB_W'(16);
               sh_tx <= MAXB'({wd_data[7:0], wd_data[15:8]});
               step <= SP_DATA; state <= ST_SHIFT;
            end
            default: if (sh_done) begin
               unique case (step)
                  SP_POLL_OP: begin
                     sh_start <= 1'b1; sh_rxm <= 1'b1; sh_bits <= NB_W'(8); sh_tx <= '0;
                     step <= SP_POLL_RD;
                  end
                  SP_POLL_RD: begin
                     spi_cs_n <= 1'b1;
                     state    <= ST_WAIT;
                     if (!sh_rx[0]) begin
                        wcnt <= 32'(CS_GAP-1); ret <= RT_WREN;
                     end else if (polls == POLL_W'(MAX_POLLS-1)) begin
                        done <= 1'b1; err <= 1'b1; state <= ST_IDLE;
                     end else begin
                        polls <= polls + POLL_W'(1);
                        wcnt <= 32'(POLL_GAP-1); ret <= RT_POLL;
                     end
                  end
                  SP_WREN: begin
                     spi_cs_n <= 1'b1; wcnt <= 32'(CS_GAP-1);
                     ret <= RT_WROP; state <= ST_WAIT;
                  end
                  SP_WROP: begin
                     sh_start <= 1'b1; sh_rxm <= 1'b0; sh_bits <= NB_W'(ADDR_W);
                     sh_tx <= MAXB'(byte_addr);
                     step <= SP_ADDR;
                  end
                  SP_ADDR: state <= ST_WORD;
                  default: begin
                     cur  <= cur + REQ_W'(1);
                     left <= left - REQ_W'(1);
                     if (left == REQ_W'(1)) begin
                        spi_cs_n <= 1'b1; wcnt <= 32'(SETTLE-1);
                        ret <= RT_FIN; state <= ST_WAIT;
                     end else if (page_end) begin
                        spi_cs_n <= 1'b1; polls <= '0; wcnt <= 32'(CS_GAP-1);
                        ret <= RT_POLL; state <= ST_WAIT;
                     end else begin
                        state <= ST_WORD;
                     end
                  end
               endcase
            end
         endcase
      end
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                          // R10
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> done);                                            // R10
   AST_CS_HIGH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> spi_cs_n);                         // R10
   AST_SCK_LOW_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      spi_cs_n |-> !spi_sck);                                   // R8
   AST_BAD_REQ_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_bad) |=> (done && err && spi_cs_n)); // R1
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (wd_ready && !wd_valid) |=> wd_ready);                    // R6
   AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      polls < POLL_W'(MAX_POLLS));                              // R2
endmodule

// File: tb/eeprom_page_writer_tb_top.sv
module eeprom_page_writer_tb_top;
   localparam int CLK_DIV = 2;
   localparam int MAXP    = 4;
   localparam int PGAP    = 20;
   localparam int SETL    = 50;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, wd_valid = 1'b0, miso = 1'b0;
   logic [15:0] req_offset = '0, req_count = '0, wd_data = '0;
   logic req_ready, wd_ready, done, err, sck, cs_n, mosi;

   always #10 clk = ~clk;

   eeprom_page_writer #(.CLK_DIV(CLK_DIV), .OPC_W(8), .ADDR_W(8), .PAGE_BYTES(32),
      .DEV_WORDS(256), .REQ_W(16), .MAX_POLLS(MAXP), .POLL_GAP(PGAP), .SETTLE(SETL)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_offset(req_offset), .req_count(req_count), .wd_valid(wd_valid),
      .wd_ready(wd_ready), .wd_data(wd_data), .done(done), .err(err),
      .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso));

   int vecs = 0, bad = 0, cyc = 0;
   bit over = 0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      vecs++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   always @(posedge clk) cyc++;

   // ---------------- device model on the pins ----------------
   int busy_left = 0, bitc = 0, mosi_viol = 0, t_csr = 0;
   bit inf = 0, st_busy = 0;
   logic [7:0] curb = '0, stat;
   int fb[$], got_q[$], exp_q[$];

   assign stat = st_busy ? 8'h81 : 8'h80;

   always @(negedge cs_n) begin
      inf = 1; bitc = 0; fb.delete(); st_busy = (busy_left > 0);
   end
   always @(posedge sck) if (inf) begin
      curb = {curb[6:0], mosi};
      bitc++;
      if (bitc % 8 == 0) fb.push_back(int'(curb));
      if (bitc > 8 && fb.size() > 0 && fb[0] == 5 && mosi) mosi_viol++;
   end
   always @(negedge sck) if (inf && fb.size() > 0 && fb[0] == 5 && bitc >= 8 && bitc < 16)
      miso = stat[15-bitc];
   always @(posedge cs_n) if (inf) begin
      inf = 0;
      foreach (fb[i]) got_q.push_back(fb[i]);
      if (bitc % 8 != 0) got_q.push_back(999);
      got_q.push_back(256);
      if (fb.size() > 0 && fb[0] == 5 && busy_left > 0) busy_left--;
      t_csr = cyc;
      miso = 1'b0;
   end

   // ---------------- per-clock checks ----------------
   bit done_prev = 0;
   int hi_run = 0;
   always @(negedge clk) if (rst_n) begin
      if (cs_n && sck) chk(0, "R10 sck high with cs high", 1, 0);
      if (done && done_prev) chk(0, "R10 done longer than one cycle", 2, 1);
      if (err && !done) chk(0, "R10 err without done", 1, 0);
      done_prev = done;
      if (sck) hi_run++;
      else if (hi_run > 0) begin
         chk(hi_run == CLK_DIV, "R8 sck high phase length", hi_run, CLK_DIV);
         hi_run = 0;
      end
   end

   // ---------------- data word source ----------------
   int wd_q[$];
   bit hs = 0;
   always @(negedge clk) begin
      if (hs) void'(wd_q.pop_front());
      wd_valid = (wd_q.size() > 0);
      wd_data  = wd_valid ? 16'(wd_q[0]) : 16'h0;
      hs = wd_valid && wd_ready;
   end

   // ---------------- expected frame builder ----------------
   int dat[$];
   task automatic plan_write(input int off, input int cnt, input int busy);
      int w, cp, np, op;
      bit first;
      w = 0; cp = off; first = 1;
      foreach (dat[i]) wd_q.push_back(dat[i]);
      while (w < cnt) begin
         np = first ? busy + 1 : 1;
         for (int k = 0; k < np; k++) begin
            exp_q.push_back(5); exp_q.push_back(0); exp_q.push_back(256);   // R2
         end
         exp_q.push_back(6); exp_q.push_back(256);                          // R3
         op = 2 | ((cp >= 128) ? 8 : 0);                                    // R4
         exp_q.push_back(op); exp_q.push_back((cp*2) & 255);                // R5
         do begin
            exp_q.push_back(dat[w] & 255); exp_q.push_back((dat[w] >> 8) & 255); // R6
            w++; cp++;
         end while (w < cnt && (cp*2) % 32 != 0);                           // R7
         exp_q.push_back(256);
         first = 0;
      end
   endtask

   task automatic do_req(input int off, input int cnt);
      @(negedge clk);
      req_valid = 1; req_offset = 16'(off); req_count = 16'(cnt);
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wait_done(output bit e, output int t);
      e = 0; t = -1;
      for (int i = 0; i < 20000; i++) begin
         if (done) begin e = err; t = cyc; break; end
         @(negedge clk);
      end
   endtask

   task automatic cmp_frames(input string tag);
      int n;
      chk(got_q.size() == exp_q.size(), {tag, " frame byte count"}, got_q.size(), exp_q.size());
      n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
      for (int i = 0; i < n; i++)
         if (got_q[i] != exp_q[i]) begin
            chk(0, {tag, " frame content"}, got_q[i], exp_q[i]);
            break;
         end
      got_q.delete(); exp_q.delete(); dat.delete();
   endtask

   task automatic run_write(input int off, input int cnt, input int busy, input string tag);
      bit e; int t;
      busy_left = busy;
      plan_write(off, cnt, busy);
      do_req(off, cnt);
      wait_done(e, t);
      chk(t >= 0, {tag, " R9 completion seen"}, t, 1);
      chk(e == 0, {tag, " R9 err flag"}, e, 0);
      chk(t - t_csr == SETL, {tag, " R9 settle cycles"}, t - t_csr, SETL);
      cmp_frames(tag);
      chk(wd_q.size() == 0, {tag, " R6 all words consumed"}, wd_q.size(), 0);
      @(negedge clk);
   endtask

   task automatic run_bad(input int off, input int cnt, input string tag);
      do_req(off, cnt);
      chk(done && err, {tag, " R1 rejected next cycle"}, {done, err}, 3);
      repeat (20) @(negedge clk);
      chk(got_q.size() == 0 && cs_n, {tag, " R1 no bus activity"}, got_q.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!over) begin
         over = 1;
         chk(0, "watchdog expired", cyc, 0);
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   initial begin
      bit e; int t;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(cs_n == 1 && sck == 0, "R10 reset idle pins", {cs_n, sck}, 2);
      chk(done == 0 && req_ready == 1 && wd_ready == 0, "R10 reset handshake state",
          {done, req_ready, wd_ready}, 2);

      dat = '{16'h1234, 16'hA5C3};
      run_write(3, 2, 2, "R2 single burst with busy polls");

      dat = '{16'h0102, 16'h0304, 16'h0506, 16'h0708, 16'h090A};
      run_write(14, 5, 0, "R7 page split");

      dat = '{16'hBEEF, 16'hCAFE, 16'h55AA, 16'hF00D};
      run_write(126, 4, 1, "R4 high address flag across 128");

      dat = '{16'h8001};
      run_write(255, 1, 0, "R5 last word of device");

      for (int i = 0; i < 16; i++) dat.push_back(16'h1111 * (i % 15) + i);
      run_write(0, 16, 0, "R7 run ends on page boundary");

      run_bad(256, 1, "R1 offset beyond size");
      run_bad(250, 7, "R1 count past end");
      run_bad(0, 0, "R1 zero count");

      busy_left = 100;
      do_req(10, 1);
      wait_done(e, t);
      chk(t >= 0 && e == 1, "R2 poll limit gives error", e, 1);
      for (int k = 0; k < MAXP; k++) begin
         exp_q.push_back(5); exp_q.push_back(0); exp_q.push_back(256);
      end
      cmp_frames("R2 poll limit frames");
      busy_left = 0;
      @(negedge clk);

      chk(mosi_viol == 0, "R8 mosi low during status read", mosi_viol, 0);

      if (!over) begin
         over = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end
endmodule